// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a synchronous request port and an external asynchronous static RAM of 65,536 words of 4 bits. The RAM has active-low chip-enable and write-enable strobes and two separate data buses: one carries data into the RAM and the other carries data out of it. A client issues single read or write commands with a 16-bit address and 4 bits of write data. Reads return the stored word together with a one-cycle valid pulse.

Each timing minimum of the RAM is a parameter given in picoseconds. At elaboration, each one is turned into a whole number of clock cycles by rounding up, and every count is at least one cycle. A write is the overlap of chip-enable low and write-enable low. The controller always ends this overlap by raising write-enable while chip-enable stays low, so the setup and hold of address and data are taken against that rising edge. All strobes come straight from flip-flops, so they do not glitch.

A ready signal stays low for the whole access, including any padding needed to meet the minimum cycle time. A request offered while ready is low is not taken.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is held and in the first cycles after it, mem_ce_n and mem_we_n are 1, req_ready is 1 and rd_valid is 0.
- R2: A request with req_write=1 taken while req_ready=1 drives mem_we_n low for exactly WLOW cycles. WLOW is the largest rounded-up count of the WE pulse width, the data setup, the address setup to write end and the CE-low to write end. During those cycles mem_ce_n is low and mem_addr and mem_din carry the accepted address and data.
- R3: A write ends with mem_we_n rising while mem_ce_n is still low. mem_addr and mem_din stay unchanged through the hold cycle that follows.
- R4: For a write, mem_ce_n stays low for max(rounded write cycle time, WLOW+1) cycles and then returns high.
- R5: A request with req_write=0 produces exactly one single-cycle rd_valid pulse. rd_data then holds the word most recently written to that address, or 0 if the address has never been written.
- R6: Read data is captured on the clock edge that comes RACC cycles after mem_ce_n falls, with rd_valid high in the cycle after that edge. RACC is the larger of the rounded address-access and CE-access counts. For a read, mem_ce_n stays low for max(rounded read cycle time, RACC) cycles.
- R7: req_ready is low from the accepting edge until the whole access, including its padding, has finished. A request presented while req_ready is 0 is ignored.
- R8: mem_we_n is never low while mem_ce_n is high, and mem_addr and mem_din do not change while mem_ce_n stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Command offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 4 | Write data |
| req_ready | output | 1 | Controller idle; command taken when req_valid is also high |
| rd_valid | output | 1 | One-cycle pulse: rd_data is valid |
| rd_data | output | 4 | Captured read word |
| mem_addr | output | 16 | Address to the RAM |
| mem_din | output | 4 | Data into the RAM |
| mem_dout | input | 4 | Data out of the RAM |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
Two situations are hard to reach from the ports: a request offered while an access is still running, and a capture made one edge too early. For the first, the stimulus presents a write to a fresh address in the cycle just after another write has been taken, while req_ready is already low. Reading that fresh address later must return 0. For the second, the bench's RAM model drives the inverted word on its output until the access time has passed, so a capture on any earlier edge returns a wrong value. The bench also uses slower timing parameters, so that the pulse widths and padding span several cycles.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LOW,
    ST_WR_HOLD,
    ST_WR_PAD,
    ST_RD_WAIT,
    ST_RD_PAD
  } ctl_state_e;

  // Round a time in ps up to whole clock cycles, never fewer than one.
  function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                               input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_rst_sync.sv
module sram_ctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int unsigned WLOW  = 1,
  parameter int unsigned HOLD  = 1,
  parameter int unsigned WPAD  = 0,
  parameter int unsigned RACC  = 2,
  parameter int unsigned RPAD  = 0,
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             tmr_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ready,
  output logic             ce_n,
  output logic             we_n
);

  ctl_state_e state_q, state_d;
  logic       ce_n_q, we_n_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR_LOW;
            tmr_val = CNT_W'(WLOW - 1);
          end else begin
            state_d = ST_RD_WAIT;
            tmr_val = CNT_W'(RACC - 1);
          end
        end
      end
      ST_WR_LOW: begin
        if (tmr_done) begin
          state_d  = ST_WR_HOLD;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(HOLD - 1);
        end
      end
      ST_WR_HOLD: begin
        if (tmr_done) begin
          if (WPAD != 0) begin
            state_d  = ST_WR_PAD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WPAD - 1);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_RD_WAIT: begin
        if (tmr_done) begin
          capture = 1'b1;
          if (RPAD != 0) begin
            state_d  = ST_RD_PAD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(RPAD - 1);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_WR_PAD, ST_RD_PAD: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      ce_n_q  <= (state_d == ST_IDLE);
      we_n_q  <= (state_d != ST_WR_LOW);
    end
  end

  assign ready = (state_q == ST_IDLE);
  assign ce_n  = ce_n_q;
  assign we_n  = we_n_q;

  // R8
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

  // R3
  we_ends_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> !ce_n);

  // R7
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !ready);

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] ram_q,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= in_addr;
      wdata_q <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= ram_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= capture;
  end

  assign addr   = addr_q;
  assign wdata  = wdata_q;
  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  // R5
  rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid);

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 4,
  parameter int unsigned CLK_PERIOD_PS = 10000,
  parameter int unsigned T_RC_PS       = 12000,
  parameter int unsigned T_AA_PS       = 12000,
  parameter int unsigned T_ACE_PS      = 12000,
  parameter int unsigned T_WC_PS       = 12000,
  parameter int unsigned T_SCE_PS      = 9000,
  parameter int unsigned T_AW_PS       = 9000,
  parameter int unsigned T_PWE_PS      = 8000,
  parameter int unsigned T_SD_PS       = 8000,
  parameter int unsigned HOLD_CYC      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_din,
  input  logic [DATA_W-1:0] mem_dout,
  output logic              mem_ce_n,
  output logic              mem_we_n
);

  localparam int unsigned C_RC   = ps_to_cycles(T_RC_PS,  CLK_PERIOD_PS);
  localparam int unsigned C_AA   = ps_to_cycles(T_AA_PS,  CLK_PERIOD_PS);
  localparam int unsigned C_ACE  = ps_to_cycles(T_ACE_PS, CLK_PERIOD_PS);
  localparam int unsigned C_WC   = ps_to_cycles(T_WC_PS,  CLK_PERIOD_PS);
  localparam int unsigned C_SCE  = ps_to_cycles(T_SCE_PS, CLK_PERIOD_PS);
  localparam int unsigned C_AW   = ps_to_cycles(T_AW_PS,  CLK_PERIOD_PS);
  localparam int unsigned C_PWE  = ps_to_cycles(T_PWE_PS, CLK_PERIOD_PS);
  localparam int unsigned C_SD   = ps_to_cycles(T_SD_PS,  CLK_PERIOD_PS);
  localparam int unsigned WLOW   = max2(max2(C_PWE, C_SD), max2(C_AW, C_SCE));
  localparam int unsigned HOLD   = max2(HOLD_CYC, 1);
  localparam int unsigned WTOT   = max2(C_WC, WLOW + HOLD);
  localparam int unsigned WPAD   = WTOT - WLOW - HOLD;
  localparam int unsigned RACC   = max2(C_AA, C_ACE);
  localparam int unsigned RTOT   = max2(C_RC, RACC);
  localparam int unsigned RPAD   = RTOT - RACC;
  localparam int unsigned MAXC   = max2(max2(WLOW, HOLD), max2(max2(WPAD, RACC), RPAD));
  localparam int unsigned CNT_W  = max2($clog2(MAXC + 1), 1);

  logic             rst_sync_n;
  logic             tmr_load, tmr_done, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  sram_ctl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  sram_ctl_fsm #(
    .WLOW (WLOW), .HOLD (HOLD), .WPAD (WPAD),
    .RACC (RACC), .RPAD (RPAD), .CNT_W (CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .tmr_done  (tmr_done),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .accept    (accept),
    .capture   (capture),
    .ready     (req_ready),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n)
  );

  sram_ctl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .accept  (accept),
    .capture (capture),
    .in_addr (req_addr),
    .in_data (req_wdata),
    .ram_q   (mem_dout),
    .addr    (mem_addr),
    .wdata   (mem_din),
    .rdata   (rd_data),
    .rvalid  (rd_valid)
  );

  // R8
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_din)));

  // R6
  capture_in_access_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rd_valid) |-> $past(!mem_ce_n));

endmodule

// File: tb/sram_async_ctl_tb_top.sv
module sram_async_ctl_tb_top;

  // Slower parameters so each phase spans several 10 ns cycles.
  localparam int EXP_WE_LOW = 2;  // ceil(15 ns / 10 ns)
  localparam int EXP_CE_WR  = 5;  // max(ceil(45/10), 2+1)
  localparam int EXP_AA     = 3;  // ceil(25/10)
  localparam int EXP_CE_RD  = 4;  // max(ceil(40/10), 3)

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr;
  logic [3:0]  req_wdata;
  logic        req_ready, rd_valid;
  logic [3:0]  rd_data, mem_din, mem_dout;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_we_n;

  always #5 clk = ~clk;

  sram_async_ctl #(
    .T_AA_PS (25000), .T_RC_PS (40000),
    .T_PWE_PS(15000), .T_WC_PS (45000)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_din(mem_din), .mem_dout(mem_dout), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n)
  );

  // RAM model: output is the inverted word until the access time has passed.
  logic [3:0] ram [int];
  logic [3:0] shadow [int];
  int         acc_cnt;

  function automatic logic [3:0] ram_word(input logic [15:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : 4'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_ce_n) begin
      acc_cnt  <= 0;
      mem_dout <= 4'hA;
    end else begin
      acc_cnt  <= acc_cnt + 1;
      mem_dout <= (acc_cnt + 1 >= EXP_AA - 1) ? ram_word(mem_addr) : ~ram_word(mem_addr);
    end
  end

  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n) ram[int'(mem_addr)] = mem_din;
  end

  int checks = 0, errors = 0;
  bit active = 0, finished = 0;
  logic [3:0] exp_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [3:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    shadow[int'(a)] = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_read(input logic [15:0] a);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
    @(negedge clk);
    req_valid = 0;
  endtask

  // Monitor / scoreboard
  bit         prev_ce = 1, prev_we = 1, prev_rv = 0, saw_we = 0;
  int         ce_len = 0, we_len = 0, since_fall = 0;
  logic [15:0] addr_we;
  logic [3:0]  din_we;

  always @(negedge clk) begin
    if (active) begin
      if (prev_ce && !mem_ce_n) begin
        ce_len = 0; since_fall = 0; saw_we = 0;
      end
      since_fall++;
      if (!mem_ce_n) begin
        ce_len++;
        check(!req_ready, "R7 ready low while busy", int'(req_ready), 0);
      end
      if (!mem_we_n) begin
        we_len++; saw_we = 1; addr_we = mem_addr; din_we = mem_din;
      end
      if (!prev_we && mem_we_n) begin
        check(we_len == EXP_WE_LOW, "R2 WE low cycles", we_len, EXP_WE_LOW);
        check(!mem_ce_n, "R3 CE low at WE rise", int'(mem_ce_n), 0);
        check(mem_addr == addr_we && mem_din == din_we, "R3 addr/data hold",
              int'({mem_addr, mem_din}), int'({addr_we, din_we}));
        we_len = 0;
      end
      if (!prev_ce && mem_ce_n) begin
        if (saw_we) check(ce_len == EXP_CE_WR, "R4 write CE low cycles", ce_len, EXP_CE_WR);
        else        check(ce_len == EXP_CE_RD, "R6 read CE low cycles", ce_len, EXP_CE_RD);
      end
      if (rd_valid) begin
        check(!prev_rv, "R5 single-cycle valid", int'(prev_rv), 0);
        check(since_fall == EXP_AA + 1, "R6 capture edge", since_fall, EXP_AA + 1);
        if (exp_q.size() == 0) check(0, "R5 unexpected rd_valid", 1, 0);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(rd_data == e, "R5 read data", int'(rd_data), int'(e));
        end
      end
      prev_ce = mem_ce_n; prev_we = mem_we_n; prev_rv = rd_valid;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    #2 rst_n = 0;
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n, "R1 strobes high in reset", int'({mem_ce_n, mem_we_n}), 3);
    check(!rd_valid, "R1 no valid in reset", int'(rd_valid), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(req_ready, "R1 ready after reset", int'(req_ready), 1);
    check(mem_ce_n && mem_we_n, "R1 strobes high after reset", int'({mem_ce_n, mem_we_n}), 3);
    active = 1;

    // Unwritten address reads 0, then extremes of the address range
    do_read(16'h0042);
    do_write(16'h0000, 4'h5);
    do_write(16'hFFFF, 4'hA);
    do_read(16'h0000);
    do_read(16'hFFFF);

    // R7: request offered while busy must be ignored
    do_write(16'h00AA, 4'h6);
    check(!req_ready, "R7 busy after accept", int'(req_ready), 0);
    req_valid = 1; req_write = 1; req_addr = 16'h00BB; req_wdata = 4'h9;
    @(negedge clk);
    req_valid = 0;
    do_read(16'h00BB);
    do_read(16'h00AA);

    // Overwrite and immediate read-back
    do_write(16'h1234, 4'h3);
    do_write(16'h1234, 4'hC);
    do_read(16'h1234);

    // Walking patterns
    for (int i = 0; i < 16; i++) do_write(16'(i * 4099), 4'(i ^ 4'h7));
    for (int i = 15; i >= 0; i--) do_read(16'(i * 4099));

    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule